// File: doc/BRIEF.md
# Nibble-Mode Parallel Register Bridge

This block is the device-side end of a narrow parallel link. The host writes one byte at a time on an 8-bit data port. The block splits each byte into three fields: a 3-bit command in bits 7:5, a half-select bit in bit 4, and a 4-bit payload in bits 3:0. The payload carries either a register index or a data nibble. Because the return path is only four lines wide, read data comes back one nibble at a time on a registered status output.

Through this port the host reaches two stores. The first is a sixteen-entry, byte-wide register file, which the host writes one nibble at a time. The second is a packet buffer, which the host streams bytes into and out of. The register file is addressed by a short sequence of bytes. An address is latched, and the data nibble is committed when the command field falls from write-address to zero. The host may repeat any byte for settling time, so every action is tied to a change between consecutive bytes or to a state that is entered only once.

Top module: `nib_port_bridge`

## Requirements
- R1: After reset, `stat_nib` is 0, every register-file entry reads 0, and both buffer pointers are at entry 0.
- R2: A register write is carried out as follows.
  - The bridge must first be idle, which a byte with command 111 brings about.
  - The first following byte with command 010 latches bits 3:0 as the register index.
  - The next change from a command-010 byte to a command-000 byte writes bits 3:0 of the command-000 byte into that register.
  - The low half (bits 3:0) is written when bit 4 of the command-000 byte is 0. The high half (bits 7:4) is written when it is 1.
- R3: The command-000 byte in R2 writes at most once per access. Repeating any byte has no effect. Any later command-000 bytes, or later command-010 bytes carrying other payloads, change no register until the next idle byte.
- R4: A command-111 byte ends the access and clears the latched address. The next command-010 byte latches a fresh index.
- R5: A command-110 byte reads a nibble. For any index except 14, `stat_nib` shows one clock later the register's low half when bit 4 is 0, or its high half when bit 4 is 1.
- R6: While the command field is anything other than 110, `stat_nib` holds its last value.
- R7: A bulk write is carried out as follows.
  - It applies only while the bridge is idle.
  - A command-000 byte with bit 4 = 0, directly followed by a command-000 byte with bit 4 = 1, stores one buffer byte at the write pointer.
  - The stored byte takes its high half from the second byte and its low half from the first.
  - The write pointer then advances by one.
  - Repeating either byte stores nothing more.
- R8: A bulk read is carried out as follows.
  - A command-110 byte with index 14 returns the buffer byte at the read pointer: its low half when bit 4 = 0, its high half when bit 4 = 1.
  - The read pointer advances when the byte 0xDE is followed by a different byte.
  - A low-half read that directly follows 0xDE already shows the next entry.
- R9: Both buffer pointers wrap from the last entry (depth 2^BUF_AW, 64 by default) back to entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the host byte is sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_byte | input | 8 | Host data port: command[7:5], half select[4], payload[3:0] |
| stat_nib | output | 4 | Registered read nibble (the status lines) |

## Verification
A wrong latched address or a missed commit writes a nibble into the wrong register, and this stays hidden until that register is read back through `stat_nib`. A wrong pointer or a double store shows up as a shifted or repeated byte on the next buffer read. A wrong bulk-write pointer appears only after the buffer has been read back up to the write position. Every read result appears one clock after its command byte, so the first readback after the fault exposes it.

// File: rtl/nib_port_bridge.sv
module nib_port_bridge #(
  parameter int BUF_AW  = 6,
  parameter int MAR_IDX = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] host_byte,
  output logic [3:0] stat_nib
);
  localparam int BUF_DEPTH = 1 << BUF_AW;
  localparam logic [2:0] C_DAT  = 3'b000;
  localparam logic [2:0] C_WA   = 3'b010;
  localparam logic [2:0] C_RA   = 3'b110;
  localparam logic [2:0] C_IDLE = 3'b111;
  localparam logic [7:0] RD_HI_MAR = {C_RA, 1'b1, 4'(MAR_IDX)};

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DONE} wst_t;

  logic [7:0] rf  [16];
  logic [7:0] mem [BUF_DEPTH];
  logic [7:0] pv;
  wst_t       wst;
  logic [3:0] addr;
  logic [BUF_AW-1:0] wptr, rptr, rptr_n;

  wire [2:0] cmd  = host_byte[7:5];
  wire       half = host_byte[4];
  wire [3:0] pay  = host_byte[3:0];

  wire commit = (wst == S_ADDR) && (cmd == C_DAT) && (pv[7:5] == C_WA);
  wire bstore = (wst == S_IDLE) && (cmd == C_DAT) && half &&
                (pv[7:5] == C_DAT) && !pv[4];
  wire radv   = (pv == RD_HI_MAR) && (host_byte != pv);

  assign rptr_n = rptr + BUF_AW'(radv);

  wire [7:0] rd_byte = (pay == 4'(MAR_IDX)) ? mem[rptr_n] : rf[pay];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv   <= {C_IDLE, 5'd0};
      wst  <= S_IDLE;
      addr <= '0;
      wptr <= '0;
      rptr <= '0;
      stat_nib <= '0;
      for (int i = 0; i < 16; i++) rf[i] <= '0;
    end else begin
      pv   <= host_byte;
      rptr <= rptr_n;
      if (bstore) wptr <= wptr + 1'b1;
      if (cmd == C_RA) stat_nib <= half ? rd_byte[7:4] : rd_byte[3:0];
      case (cmd)
        C_IDLE: begin
          wst  <= S_IDLE;
          addr <= '0;
        end
        C_WA: if (wst == S_IDLE) begin
          addr <= pay;
          wst  <= S_ADDR;
        end
        C_DAT: if (commit) begin
          wst <= S_DONE;
          if (half) rf[addr][7:4] <= pay;
          else      rf[addr][3:0] <= pay;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && bstore) mem[wptr] <= {pay, pv[3:0]};
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != C_RA) |=> $stable(stat_nib));

  p_repeat_no_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_byte == pv) |=> $stable(wptr));

  p_repeat_no_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_byte == pv) |=> $stable(rptr));

  p_idle_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_IDLE) |=> (wst == S_IDLE && addr == 4'd0));

  p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wst == S_DONE && cmd != C_IDLE) |=> (wst == S_DONE));

  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (wptr == $past(wptr) || wptr == $past(wptr) + 1'b1));
endmodule

// File: tb/sim_nib_port_bridge.sv
`timescale 1ns/1ps
module sim_nib_port_bridge;
  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] host_byte = 8'hE0;
  logic [3:0] stat_nib;

  int checks = 0;
  int errors = 0;
  logic [7:0] mrf [16];
  logic [7:0] mbuf [64];
  int wp = 0;
  int rp = 0;

  always #2 clk = ~clk;

  nib_port_bridge u0 (.clk(clk), .rst_n(rst_n), .host_byte(host_byte), .stat_nib(stat_nib));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    host_byte = b;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [3:0] half_of(input logic [7:0] v, input bit hi);
    return hi ? v[7:4] : v[3:0];
  endfunction

  task automatic wr_nib(input logic [3:0] a, input logic [3:0] v, input bit hi, input bit dbl);
    logic [7:0] h;
    h = hi ? 8'h10 : 8'h00;
    send(8'hE0 | h | a);
    send(8'h40 | h | a);
    if (dbl) send(8'h40 | h | a);
    send(8'h40 | h | v);
    send(h | v);
    if (dbl) send(h | v);
    send(8'hE0 | h | v);
    if (hi) mrf[a][7:4] = v; else mrf[a][3:0] = v;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input bit hi);
    logic [7:0] h;
    h = hi ? 8'h10 : 8'h00;
    send(8'hE0 | a);
    send(8'hC0 | h | a);
    chk(tag, stat_nib, half_of(mrf[a], hi));
    send(8'hE0 | a);
  endtask

  task automatic bulk_wr(input logic [7:0] v, input bit dbl);
    send({4'h0, v[3:0]});
    if (dbl) send({4'h0, v[3:0]});
    send({4'h1, v[7:4]});
    if (dbl) send({4'h1, v[7:4]});
    mbuf[wp % 64] = v;
    wp++;
  endtask

  task automatic bulk_rd(input string tag, input bit dbl);
    send(8'hCE);
    if (dbl) send(8'hCE);
    chk(tag, stat_nib, mbuf[rp % 64][3:0]);
    send(8'hDE);
    if (dbl) send(8'hDE);
    chk(tag, stat_nib, mbuf[rp % 64][7:4]);
    rp++;
  endtask

  function automatic logic [3:0] pick_addr();
    logic [3:0] a;
    a = 4'($urandom_range(0, 14));
    if (a == 4'd14) a = 4'd15;
    return a;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16; i++) mrf[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    #1;
    chk("R1 reset status", stat_nib, 4'h0);
    rd_chk("R1 reset reg3 lo", 4'd3, 1'b0);
    rd_chk("R1 reset reg9 hi", 4'd9, 1'b1);

    // R2: directed writes to both halves
    wr_nib(4'd5, 4'hA, 1'b0, 1'b0);
    wr_nib(4'd5, 4'h3, 1'b1, 1'b1);
    rd_chk("R2 reg5 lo", 4'd5, 1'b0);
    rd_chk("R2 reg5 hi", 4'd5, 1'b1);

    // R3: extra commit-like bytes after the commit do nothing
    send(8'hE2); send(8'h42); send(8'h47); send(8'h07);
    send(8'h4C); send(8'h0C); send(8'h0C); send(8'hE0);
    mrf[2][3:0] = 4'h7;
    rd_chk("R3 single commit reg2 lo", 4'd2, 1'b0);

    // R4: idle mid-access restarts address latch
    send(8'h41); send(8'hE0); send(8'h46); send(8'h49); send(8'h09); send(8'hE9);
    mrf[6][3:0] = 4'h9;
    rd_chk("R4 relatch reg6 lo", 4'd6, 1'b0);
    rd_chk("R4 reg1 untouched lo", 4'd1, 1'b0);

    // R6: status holds through non-read bytes
    send(8'hC5);
    held = {4'h0, stat_nib};
    send(8'hE0); send(8'hFF); send(8'hE7);
    chk("R6 hold", stat_nib, held[3:0]);

    // R5/R2 random register traffic
    for (int n = 0; n < 60; n++) begin
      wr_nib(pick_addr(), 4'($urandom), 1'($urandom), 1'($urandom));
    end
    for (int n = 0; n < 40; n++) begin
      rd_chk("R5 random read", pick_addr(), 1'($urandom));
    end

    // R7/R8: bulk traffic, with and without repeats
    send(8'hE0);
    for (int n = 0; n < 10; n++) bulk_wr(8'($urandom), 1'(n % 2));
    send(8'hE0);
    for (int n = 0; n < 10; n++) bulk_rd("R8 bulk read", 1'(n % 3 == 0));
    send(8'hE0);
    bulk_wr(8'h5A, 1'b1);
    send(8'hE0);
    bulk_rd("R7 repeat store once", 1'b1);
    send(8'hE0);

    // R9: wrap both pointers
    for (int n = 0; n < 60; n++) bulk_wr(8'($urandom), 1'b0);
    send(8'hE0);
    for (int n = 0; n < 60; n++) bulk_rd("R9 wrap read", 1'b0);
    send(8'hE0);
    chk("R9 pointers wrapped", 4'(rp % 64 == 7), 4'h1);
    bulk_rd("R9 entry after wrap", 1'b0);
    send(8'hE0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule